// File: doc/BRIEF.md
# Host configuration access translator

This block sits in a host bridge between the processor's I/O port space and the downstream configuration bus. It keeps a 32-bit address-select register at I/O port 0CF8h. It also watches the DWORD data window at 0CFCh. When the window is hit and the select register is enabled, it turns the access into a configuration address word. That word is either a local (Type 0) form with a one-hot device-select vector, or a forwarded (Type 1) form for buses further downstream.

Two registers hold the bridge's own bus number and its subordinate (highest downstream) bus number. The block uses them to classify every data-window access as local, behind the bridge, or unclaimed. Local accesses to devices it cannot select are finished inside the block. Running the actual bus transaction is left to the logic downstream. The block only reports the access class, the address word, the byte enables and the device-select vector.

The control is a two-state machine. In `ST_IDLE` the block asserts `io_ready`. An access taken in `ST_IDLE` (transition *accept*) is decoded and registered, and the machine moves to `ST_RESP`. In `ST_RESP` the block shows the result with `rsp_valid` for exactly one cycle and then takes transition *retire* back to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `cfg_xlate_top`

## Requirements
- R1: The select register changes only on an accepted write with `io_be` = 4'b1111 to the DWORD at 0CF8h. Its bits 30:24 and 1:0 always hold 0. Bit 31 is enable, 23:16 bus, 15:11 device, 10:8 function, 7:2 register.
- R2: An accepted read with `io_be` = 4'b1111 to 0CF8h reports class 1 (select register) with `rsp_rdata` equal to the register. A full write to 0CF8h also reports class 1 with `rsp_rdata` = 0.
- R3: An access to 0CF8h with any other byte-enable pattern reports class 0 (plain I/O) and leaves the select register unchanged.
- R4: An access to the 0CFCh DWORD while enable is 0 reports class 0. So does an access to any address outside both DWORDs.
- R5: With enable 1 and the select bus equal to the bridge bus number, the class is 2 (Type 0). `cfg_addr` then holds the function and register fields in bits 10:2, with bits 1:0 = 00 and every other bit 0.
- R6: For class 2, `cfg_idsel` has exactly the bit numbered by the device field set. In every other class `cfg_idsel` is 0.
- R7: With enable 1 and the bus greater than the bridge bus number and at most the subordinate number, the class is 3 (Type 1). `cfg_addr` then equals the select register with bit 31 cleared and bits 1:0 = 01.
- R8: With enable 1 and the bus below the bridge bus number or above the subordinate number, the class is 5 (unclaimed), and `cfg_addr` and `cfg_idsel` are 0.
- R9: A local access to device 16 or higher reports class 4 (finished locally) with `cfg_idsel` = 0. A read then returns all ones in `rsp_rdata`, and a write returns 0.
- R10: In classes 2 and 3, `cfg_be` equals the accepted `io_be`.
- R11: After reset `io_ready` is 1 and `rsp_valid` is 0. An accepted access gives `rsp_valid` high for exactly the next cycle, during which `io_ready` is 0.
- R12: A cycle with `win_load` high loads the bridge and subordinate bus numbers from `win_sec_bus` and `win_sub_bus`. The loaded values govern accesses accepted from the next cycle on. Both registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Processor I/O access present |
| io_ready | output | 1 | Block can accept an access this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | Byte enables, active high |
| io_wdata | input | 32 | Write data |
| win_load | input | 1 | Load bus-number registers |
| win_sec_bus | input | 8 | Bridge bus number to load |
| win_sub_bus | input | 8 | Subordinate bus number to load |
| rsp_valid | output | 1 | Result of the previous accepted access |
| rsp_kind | output | 3 | Access class code |
| rsp_rdata | output | 32 | Read data returned by the block |
| cfg_addr | output | 32 | Configuration address word |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_idsel | output | 16 | One-hot device select for local accesses |

## Verification
The bench probes both edges of the bus window: exactly the bridge number, one above it, the subordinate value itself, one past it, and one below the bridge number. A design with an off-by-one compare would misclassify one of these as forwarded or unclaimed. It covers devices 15 and 16, where a decoder that wraps or truncates the device number would raise a select line instead of finishing locally with all ones. Partial writes to the select register are followed by a full read-back, so a design that latches on any write would be caught. It also hits the data window at a non-zero byte offset, and it reloads the window registers so that stale bus numbers would show up.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam int unsigned DW       = 32;
    localparam int unsigned BUS_W    = 8;
    localparam int unsigned DEV_W    = 5;
    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned BUS_LSB  = 16;
    localparam int unsigned DEV_LSB  = 11;
    localparam int unsigned ROUTE_HI = 10;   // top of function+register field
    localparam int unsigned ROUTE_LO = 2;

    typedef enum logic [2:0] {
        KIND_IO_PASS   = 3'd0,
        KIND_ADDR_REG  = 3'd1,
        KIND_T0        = 3'd2,
        KIND_T1        = 3'd3,
        KIND_LOCAL     = 3'd4,
        KIND_UNCLAIMED = 3'd5
    } xlate_kind_e;

    typedef enum logic [1:0] {
        WIN_LOCAL  = 2'd0,
        WIN_BEHIND = 2'd1,
        WIN_NONE   = 2'd2
    } win_cls_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

endpackage

// File: rtl/cfg_sel_reg.sv
module cfg_sel_reg
    import cfg_xlate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam logic [DW-1:0] KEEP_MASK = 32'h80FF_FFFC;

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata & KEEP_MASK;
    end

    // R1: the register moves only after a qualifying write
    a_r1_update_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> $past(wr_en));

endmodule

// File: rtl/cfg_bus_window.sv
module cfg_bus_window
    import cfg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] sec_in,
    input  logic [BUS_W-1:0] sub_in,
    input  logic [BUS_W-1:0] bus,
    output win_cls_e         cls
);
    logic [BUS_W-1:0] sec_q;
    logic [BUS_W-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            sub_q <= '0;
        end else if (load) begin
            sec_q <= sec_in;
            sub_q <= sub_in;
        end
    end

    always_comb begin
        if (bus == sec_q)
            cls = WIN_LOCAL;
        else if ((bus > sec_q) && (bus <= sub_q))
            cls = WIN_BEHIND;
        else
            cls = WIN_NONE;
    end

    // R12: a bus equal to the loaded bridge number is always local
    a_r12_local_match: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == sec_q) |-> (cls == WIN_LOCAL));

endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec
    import cfg_xlate_pkg::*;
#(
    parameter int unsigned IDSEL_W = 16
) (
    input  logic [DEV_W-1:0]   dev,
    input  logic               en,
    output logic               dev_ok,
    output logic [IDSEL_W-1:0] idsel
);
    assign dev_ok = ({27'd0, dev} < 32'(IDSEL_W));

    for (genvar g = 0; g < IDSEL_W; g++) begin : g_line
        assign idsel[g] = en && (dev == DEV_W'(g));
    end

endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
    import cfg_xlate_pkg::*;
#(
    parameter int unsigned   IO_AW     = 16,
    parameter int unsigned   IDSEL_W   = 16,
    parameter logic [15:0]   SEL_PORT  = 16'h0CF8,
    parameter logic [15:0]   DATA_PORT = 16'h0CFC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_valid,
    output logic               io_ready,
    input  logic               io_write,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [3:0]         io_be,
    input  logic [31:0]        io_wdata,
    input  logic               win_load,
    input  logic [7:0]         win_sec_bus,
    input  logic [7:0]         win_sub_bus,
    output logic               rsp_valid,
    output logic [2:0]         rsp_kind,
    output logic [31:0]        rsp_rdata,
    output logic [31:0]        cfg_addr,
    output logic [3:0]         cfg_be,
    output logic [IDSEL_W-1:0] cfg_idsel
);
    localparam logic [IO_AW-1:0] SEL_DW  = IO_AW'(SEL_PORT);
    localparam logic [IO_AW-1:0] DATA_DW = IO_AW'(DATA_PORT);

    fsm_e                state_q, state_d;
    logic [DW-1:0]       sel_q;
    win_cls_e            win_cls;
    logic                dev_ok;
    logic [IDSEL_W-1:0]  idsel_raw;

    logic                accept, hit_sel, hit_data, full_dw, sel_wr;
    xlate_kind_e         kind_d;
    logic [31:0]         rdata_d, addr_d;
    logic [3:0]          be_d;
    logic                t0_sel;

    xlate_kind_e         kind_q;
    logic [31:0]         rdata_q, addr_q;
    logic [3:0]          be_q;
    logic [IDSEL_W-1:0]  idsel_q;

    assign accept   = io_valid && (state_q == ST_IDLE);
    assign hit_sel  = (io_addr[IO_AW-1:2] == SEL_DW[IO_AW-1:2]);
    assign hit_data = (io_addr[IO_AW-1:2] == DATA_DW[IO_AW-1:2]);
    assign full_dw  = (io_be == 4'b1111);
    assign sel_wr   = accept && hit_sel && full_dw && io_write;

    cfg_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel_wr),
        .wdata (io_wdata),
        .q     (sel_q)
    );

    cfg_bus_window u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_load),
        .sec_in (win_sec_bus),
        .sub_in (win_sub_bus),
        .bus    (sel_q[BUS_LSB +: BUS_W]),
        .cls    (win_cls)
    );

    cfg_idsel_dec #(.IDSEL_W(IDSEL_W)) u_dec (
        .dev    (sel_q[DEV_LSB +: DEV_W]),
        .en     (t0_sel),
        .dev_ok (dev_ok),
        .idsel  (idsel_raw)
    );

    // access classification
    always_comb begin
        kind_d  = KIND_IO_PASS;
        rdata_d = '0;
        addr_d  = '0;
        be_d    = '0;
        t0_sel  = 1'b0;
        if (hit_sel && full_dw) begin
            kind_d  = KIND_ADDR_REG;
            rdata_d = io_write ? 32'd0 : sel_q;
        end else if (hit_data && sel_q[EN_BIT]) begin
            unique case (win_cls)
                WIN_LOCAL: begin
                    if (dev_ok) begin
                        kind_d = KIND_T0;
                        t0_sel = 1'b1;
                        addr_d[ROUTE_HI:ROUTE_LO] = sel_q[ROUTE_HI:ROUTE_LO];
                        be_d   = io_be;
                    end else begin
                        kind_d  = KIND_LOCAL;
                        rdata_d = io_write ? 32'd0 : 32'hFFFF_FFFF;
                    end
                end
                WIN_BEHIND: begin
                    kind_d = KIND_T1;
                    addr_d = {1'b0, sel_q[30:1], 1'b1};
                    be_d   = io_be;
                end
                default: kind_d = KIND_UNCLAIMED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = io_valid ? ST_RESP : ST_IDLE;   // accept
            ST_RESP: state_d = ST_IDLE;                        // retire
            default: state_d = ST_IDLE;
        endcase
    end

    // response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_IO_PASS;
            rdata_q <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            idsel_q <= '0;
        end else if (accept) begin
            kind_q  <= kind_d;
            rdata_q <= rdata_d;
            addr_q  <= addr_d;
            be_q    <= be_d;
            idsel_q <= idsel_raw;
        end
    end

    // outputs
    always_comb begin
        io_ready  = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_kind  = kind_q;
        rsp_rdata = rdata_q;
        cfg_addr  = addr_q;
        cfg_be    = be_q;
        cfg_idsel = idsel_q;
    end

    // R11: handshake timing
    a_r11_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r11_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready) |=> (rsp_valid && !io_ready));
    // R6: select vector is one-hot or empty, and only for local translations
    a_r6_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_idsel));
    a_r6_idsel_only_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cfg_idsel != '0) |-> (rsp_kind == KIND_T0));
    // R5 / R7: low address bits per translation form
    a_r5_t0_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_T0) |-> (cfg_addr[1:0] == 2'b00));
    a_r7_t1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_T1) |-> (cfg_addr[1:0] == 2'b01 && !cfg_addr[31]));

endmodule

// File: tb/cfg_xlate_top_tb_top.sv
module cfg_xlate_top_tb_top;

    localparam int K_IO = 0, K_AREG = 1, K_T0 = 2, K_T1 = 3, K_LOCAL = 4, K_UNCL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0, win_load = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [7:0]  win_sec_bus = '0, win_sub_bus = '0;
    logic        io_ready, rsp_valid;
    logic [2:0]  rsp_kind;
    logic [31:0] rsp_rdata, cfg_addr;
    logic [3:0]  cfg_be;
    logic [15:0] cfg_idsel;

    int vectors = 0;
    int fails = 0;
    string cur_tag = "R11";

    // reference model state
    logic [31:0] m_sel;
    int          m_sec, m_sub;
    bit          m_resp;
    int          e_kind;
    logic [31:0] e_rdata, e_addr;
    logic [3:0]  e_be;
    logic [15:0] e_idsel;
    string       e_tag;

    always #10 clk = ~clk;

    cfg_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_ready(io_ready),
        .io_write(io_write), .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .win_load(win_load), .win_sec_bus(win_sec_bus), .win_sub_bus(win_sub_bus),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_idsel(cfg_idsel)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_sec = 0; m_sub = 0; m_resp = 0;
        end else if (m_resp) begin
            m_resp = 0;
        end else if (io_valid) begin
            int bus, dev;
            bit hs, hd;
            bus = int'(m_sel[23:16]);
            dev = int'(m_sel[15:11]);
            hs = (io_addr >= 16'h0CF8) && (io_addr <= 16'h0CFB);
            hd = (io_addr >= 16'h0CFC) && (io_addr <= 16'h0CFF);
            e_kind = K_IO; e_rdata = 0; e_addr = 0; e_be = 0; e_idsel = 0;
            e_tag = cur_tag;
            if (hs && io_be == 4'hF) begin
                e_kind = K_AREG;
                if (!io_write) e_rdata = m_sel;
                else m_sel = io_wdata & 32'h80FF_FFFC;
            end else if (hd && m_sel[31]) begin
                if (bus == m_sec) begin
                    if (dev < 16) begin
                        e_kind = K_T0; e_addr = m_sel & 32'h0000_07FC;
                        e_be = io_be; e_idsel = 16'(1) << dev;
                    end else begin
                        e_kind = K_LOCAL; e_rdata = io_write ? 32'd0 : 32'hFFFF_FFFF;
                    end
                end else if (bus > m_sec && bus <= m_sub) begin
                    e_kind = K_T1; e_addr = (m_sel & 32'h7FFF_FFFC) | 32'd1; e_be = io_be;
                end else begin
                    e_kind = K_UNCL;
                end
            end
            m_resp = 1;
        end
        if (rst_n && win_load) begin
            m_sec = int'(win_sec_bus); m_sub = int'(win_sub_bus);
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            chk("R11", "io_ready", 32'(io_ready), 32'(!m_resp));
            chk("R11", "rsp_valid", 32'(rsp_valid), 32'(m_resp));
            if (m_resp && rsp_valid) begin
                chk(e_tag, "kind", 32'(rsp_kind), 32'(e_kind));
                chk(e_tag, "rdata", rsp_rdata, e_rdata);
                chk(e_tag, "cfg_addr", cfg_addr, e_addr);
                chk(e_tag, "cfg_be", 32'(cfg_be), 32'(e_be));
                chk(e_tag, "cfg_idsel", 32'(cfg_idsel), 32'(e_idsel));
            end
        end
    end

    task automatic access(string tag, bit wr, logic [15:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        while (!io_ready) @(negedge clk);
        cur_tag = tag;
        io_valid = 1; io_write = wr; io_addr = a; io_be = be; io_wdata = d;
        @(negedge clk);
        io_valid = 0;
    endtask

    task automatic load_win(logic [7:0] s, logic [7:0] u);
        @(negedge clk);
        win_load = 1; win_sec_bus = s; win_sub_bus = u;
        @(negedge clk);
        win_load = 0;
    endtask

    function automatic logic [31:0] sel(bit en, int bus, int dev, int fn, int rg);
        return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
    endfunction

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL R11 watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1;                                           // R11 reset state compared each cycle
        load_win(8'd2, 8'd5);                                // R12
        access("R4", 0, 16'h0CFC, 4'hF, 0);                  // enable clear
        access("R1", 1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF);      // reserved bits drop
        access("R1", 0, 16'h0CF8, 4'hF, 0);
        access("R8", 0, 16'h0CFC, 4'hF, 0);                  // bus 255 above window
        access("R3", 1, 16'h0CF8, 4'b0011, 32'h0);           // partial write ignored
        access("R3", 1, 16'h0CFA, 4'b1100, 32'h0);
        access("R3", 0, 16'h0CF8, 4'hF, 0);                  // read back unchanged
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 3, 5, 17));
        access("R2", 0, 16'h0CF8, 4'hF, 0);
        access("R5", 0, 16'h0CFC, 4'b0101, 0);               // R6 R10
        access("R10", 1, 16'h0CFE, 4'b1100, 32'h1234_5678);
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 15, 7, 63) | 32'h7F00_0003);
        access("R6", 0, 16'h0CFC, 4'hF, 0);                  // device 15
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 16, 0, 0));
        access("R9", 0, 16'h0CFC, 4'hF, 0);                  // device 16 read
        access("R9", 1, 16'h0CFC, 4'hF, 32'hAAAA_5555);
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 31, 1, 2));
        access("R9", 0, 16'h0CFD, 4'b0010, 0);
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 3, 31, 6, 40));
        access("R7", 0, 16'h0CFC, 4'b1001, 0);               // bus just above bridge
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 5, 1, 1, 1));
        access("R7", 1, 16'h0CFC, 4'hF, 0);                  // bus at subordinate
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 6, 1, 1, 1));
        access("R8", 0, 16'h0CFC, 4'hF, 0);                  // one past subordinate
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 1, 1, 1, 1));
        access("R8", 0, 16'h0CFC, 4'hF, 0);                  // below bridge
        access("R2", 1, 16'h0CF8, 4'hF, sel(0, 2, 4, 0, 0));
        access("R4", 0, 16'h0CFC, 4'hF, 0);                  // disabled, bus local
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 4, 0, 0));
        access("R4", 0, 16'h0080, 4'hF, 0);                  // unrelated port
        access("R4", 1, 16'h0CF4, 4'hF, 0);
        load_win(8'd5, 8'd5);                                // R12 reload
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 5, 0, 2, 9));
        access("R12", 0, 16'h0CFC, 4'hF, 0);
        access("R2", 1, 16'h0CF8, 4'hF, sel(1, 2, 0, 2, 9));
        access("R12", 0, 16'h0CFC, 4'hF, 0);                 // old bridge number now unclaimed
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule